// File: doc/BRIEF.md
# Snapshot System Timer with Match Channels

This block is a memory-mapped system timer. Its core is a free-running 64-bit up-counter. A programmable prescaler sets the rate at which the counter advances. Software can preset the counter one 32-bit half at a time. Because the two halves cannot be read in one bus access, software reads the count only through a snapshot: a latch command copies the full 64-bit value into a pair of holding registers in one cycle, and both halves are then read back from there.

Six 32-bit match channels watch the low half of the counter. Each channel sets a sticky status bit when the low half steps onto its value. An enable mask selects which status bits drive the single registered interrupt line. Channel 5 can also be armed as a watchdog. Once armed, a hit on that channel raises a reset request that stays high until the block itself is reset. All access goes through a simple single-cycle register bus: writes are taken on the clock edge and reads are combinational.

Top module: `snap_timer`

## Requirements
- R1: The counter is 64 bits wide and increments by one on each prescaler tick. A carry out of the low half goes into the high half. Writing offset 0x00 presets the low half and writing offset 0x04 presets the high half, and reads of these two offsets return the live halves.
- R2: A tick occurs once every 2 × (D + 1) clocks, where D is the divider register at offset 0x2C (reset value 0). Writing the divider restarts the prescaler phase, so the next tick comes 2 × (D + 1) clocks after that write.
- R3: A write to offset 0x30 with bit 0 set copies the live 64-bit counter, as it was before that clock edge, into the snapshot registers. The low half reads at 0x34 and the high half at 0x38. A write with bit 0 clear changes nothing. Offset 0x30 reads as zero.
- R4: If a counter preset write and a tick fall in the same cycle, the written half takes the written value and the counter does not increment in that cycle.
- R5: Match register n (n = 0 to 5) is at offset 0x08 + 4n. Status bit n at offset 0x20 is set on a tick that makes the low counter half equal to match n. A preset that loads a matching value does not set it.
- R6: A match is an edge event. After a status bit is cleared, it is not set again while the counter stays on the matching value.
- R7: Writing 1 to bit n of offset 0x20 clears status bit n. Writing 0 leaves the bit unchanged. When a clear and a hit arrive for the same bit in the same cycle, the bit ends up set.
- R8: The interrupt output equals the OR over n of (status n AND enable n), one clock later. The enable mask is bits 5:0 at offset 0x24. Changing the mask never changes the status bits.
- R9: When bit 0 of offset 0x28 is set and channel 5 hits, the reset request output rises in the same edge as status bit 5. It then stays high until reset.
- R10: Reads from any offset outside the map, including misaligned offsets and 0x3C and above, return zero. Writes to them change no state.
- R11: The match registers, the enable mask and the watchdog arm bit read back the values last written to them, and all of them reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Combinational read data for bus_addr |
| irq | output | 1 | Registered interrupt request |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with its default parameters: 32-bit halves and a 32-bit divider. It keeps the divider at small values (0, 2, 15) so that many ticks fit in a short run. The counter is preset just below 2^32, which puts the carry into the high half and the wrap of the match compare within a few hundred cycles. The restart on a divider write lets the bench place a status clear while the counter is still sitting on a matching value. Runs of back-to-back preset and clear writes at divider 0 produce same-cycle preset/tick and clear/hit collisions.

// File: rtl/snap_timer_pkg.sv
// Package: register offsets and channel constants shared by the timer modules.
// Assumes a byte-addressed bus with word-aligned registers.
package snap_timer_pkg;
    localparam int ADDR_W    = 8;
    localparam int MATCH_CNT = 6;
    localparam int WDOG_CH   = 5;

    typedef logic [ADDR_W-1:0] ofs_t;

    localparam ofs_t OFS_CNT_LO = 8'h00;
    localparam ofs_t OFS_CNT_HI = 8'h04;
    localparam ofs_t OFS_MATCH0 = 8'h08;
    localparam ofs_t OFS_STATUS = 8'h20;
    localparam ofs_t OFS_IRQ_EN = 8'h24;
    localparam ofs_t OFS_WDOG   = 8'h28;
    localparam ofs_t OFS_DIV    = 8'h2C;
    localparam ofs_t OFS_LATCH  = 8'h30;
    localparam ofs_t OFS_SNAP_L = 8'h34;
    localparam ofs_t OFS_SNAP_H = 8'h38;

    // Byte offset of match register n.
    function automatic ofs_t match_ofs(input int n);
        return OFS_MATCH0 + ofs_t'(4 * n);
    endfunction
endpackage

// File: rtl/snap_timer_prescale.sv
// Prescaler: emits a one-cycle tick every 2*(div_val+1) clocks.
// Assumes div_val is stable except at the cycle it is written; restart zeroes the phase.
module snap_timer_prescale #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             restart,
    output logic             tick
);
    localparam int PC_W = DIV_W + 1;

    logic [PC_W-1:0] phase_q;

    // Tick on the last phase of the period, which is 2*div+1.
    assign tick = (phase_q == {div_val, 1'b1});

    // Phase counter: wraps on a tick and restarts on a divider write.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (restart || tick)  phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/snap_timer_count.sv
// 64-bit counter made of two presettable halves, with a one-cycle snapshot copy.
// Assumes wr_lo and wr_hi are mutually exclusive; a preset suppresses that cycle's increment.
module snap_timer_count #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                latch,
    output logic [2*HALF_W-1:0] cnt,
    output logic [2*HALF_W-1:0] snap,
    output logic [HALF_W-1:0]   lo_next,
    output logic                inc
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] cnt_plus;

    assign cnt_plus = cnt_q + 1'b1;
    assign inc      = tick && !wr_lo && !wr_hi;
    assign lo_next  = cnt_plus[HALF_W-1:0];
    assign cnt      = cnt_q;
    assign snap     = snap_q;

    // Live counter: preset one half, otherwise step on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_lo) cnt_q <= {cnt_q[CNT_W-1:HALF_W], wdata};
        else if (wr_hi) cnt_q <= {wdata, cnt_q[HALF_W-1:0]};
        else if (inc)   cnt_q <= cnt_plus;
    end

    // Snapshot: copy the pre-edge counter on a latch command.
    always_ff @(posedge clk) begin
        if (!rst_n)     snap_q <= '0;
        else if (latch) snap_q <= cnt_q;
    end

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt_q));
    // R4
    preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q[HALF_W-1:0] == $past(wdata));
    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(snap_q));
    // R3
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> snap_q == $past(cnt_q));
endmodule

// File: rtl/snap_timer_match.sv
// One match channel: compare register, edge-detected hit and a sticky write-1-to-clear status bit.
// Assumes inc marks a cycle in which the counter steps to lo_next.
module snap_timer_match #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              inc,
    input  logic [HALF_W-1:0] lo_next,
    input  logic              clr,
    output logic [HALF_W-1:0] mval,
    output logic              hit,
    output logic              status
);
    logic [HALF_W-1:0] mval_q;
    logic              stat_q;

    assign hit    = inc && (lo_next == mval_q);
    assign mval   = mval_q;
    assign status = stat_q;

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)  mval_q <= '0;
        else if (wr) mval_q <= wdata;
    end

    // Sticky status: a hit sets it and beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   stat_q <= 1'b0;
        else if (hit) stat_q <= 1'b1;
        else if (clr) stat_q <= 1'b0;
    end

    // R5
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !status);
endmodule

// File: rtl/snap_timer.sv
// Top: register decode, match channels, interrupt combine and watchdog request.
// Assumes a single-cycle bus: writes are taken on the edge and reads are combinational.
module snap_timer
    import snap_timer_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int DIV_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdog_rst_req
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]                 cnt, snap;
    logic [HALF_W-1:0]                lo_next;
    logic                             tick, inc;
    logic [MATCH_CNT-1:0]             hit, status, ie_q;
    logic [MATCH_CNT-1:0][HALF_W-1:0] mval;
    logic [DIV_W-1:0]                 div_q;
    logic                             wde_q, irq_q, wdog_q;
    logic                             we_div, we_stat;

    assign we_div  = bus_we && (bus_addr == OFS_DIV);
    assign we_stat = bus_we && (bus_addr == OFS_STATUS);

    snap_timer_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .div_val(div_q), .restart(we_div), .tick(tick)
    );

    snap_timer_count #(.HALF_W(HALF_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(bus_we && (bus_addr == OFS_CNT_LO)),
        .wr_hi(bus_we && (bus_addr == OFS_CNT_HI)),
        .wdata(bus_wdata),
        .latch(bus_we && (bus_addr == OFS_LATCH) && bus_wdata[0]),
        .cnt(cnt), .snap(snap), .lo_next(lo_next), .inc(inc)
    );

    for (genvar n = 0; n < MATCH_CNT; n++) begin : g_ch
        snap_timer_match #(.HALF_W(HALF_W)) u_match (
            .clk(clk), .rst_n(rst_n),
            .wr(bus_we && (bus_addr == match_ofs(n))),
            .wdata(bus_wdata), .inc(inc), .lo_next(lo_next),
            .clr(we_stat && bus_wdata[n]),
            .mval(mval[n]), .hit(hit[n]), .status(status[n])
        );
    end

    // Control registers: enable mask, watchdog arm bit, divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= '0;
            wde_q <= 1'b0;
            div_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_IRQ_EN) ie_q  <= bus_wdata[MATCH_CNT-1:0];
            if (bus_addr == OFS_WDOG)   wde_q <= bus_wdata[0];
            if (bus_addr == OFS_DIV)    div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // Registered interrupt: enabled status bits ORed together.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & ie_q);
    end

    // Watchdog request: set by an armed channel hit, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wdog_q <= 1'b0;
        else if (hit[WDOG_CH] && wde_q)    wdog_q <= 1'b1;
    end

    // Read mux: fixed registers, then match registers; anything else reads zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt[HALF_W-1:0];
            OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF_W];
            OFS_STATUS: bus_rdata[MATCH_CNT-1:0] = status;
            OFS_IRQ_EN: bus_rdata[MATCH_CNT-1:0] = ie_q;
            OFS_WDOG:   bus_rdata[0] = wde_q;
            OFS_DIV:    bus_rdata[DIV_W-1:0] = div_q;
            OFS_SNAP_L: bus_rdata = snap[HALF_W-1:0];
            OFS_SNAP_H: bus_rdata = snap[CNT_W-1:HALF_W];
            default:    ;
        endcase
        for (int n = 0; n < MATCH_CNT; n++) begin
            if (bus_addr == match_ofs(n)) bus_rdata = mval[n];
        end
    end

    assign irq          = irq_q;
    assign wdog_rst_req = wdog_q;

    // R9
    wdog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_q) |-> $past(hit[WDOG_CH] && wde_q));
    // R9
    wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_q |=> wdog_q);
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |=> !irq_q);
endmodule

// File: tb/snap_timer_bench.sv
// Bench: a behavioural reference model is stepped every clock and compared with the outputs.
module snap_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdog_rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    snap_timer u_snap_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    // Reference model state.
    logic [63:0] m_cnt = '0, m_snap = '0;
    logic [31:0] m_match [6];
    logic [5:0]  m_stat = '0, m_ie = '0;
    logic        m_wde = 0, m_irq = 0, m_wdog = 0;
    longint      m_pc = 0, m_div = 0;
    int          rot = 0;

    initial for (int i = 0; i < 6; i++) m_match[i] = '0;

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h00 || a == 8'h04) return "R1 R2 R4";
        if (a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) return "R5 R11";
        case (a)
            8'h20: return "R5 R6 R7";
            8'h24, 8'h28: return "R11";
            8'h2C: return "R2";
            8'h30, 8'h34, 8'h38: return "R3";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) return m_match[(a - 8'h08) >> 2];
        case (a)
            8'h00: return m_cnt[31:0];
            8'h04: return m_cnt[63:32];
            8'h20: return {26'd0, m_stat};
            8'h24: return {26'd0, m_ie};
            8'h28: return {31'd0, m_wde};
            8'h2C: return 32'(m_div);
            8'h34: return m_snap[31:0];
            8'h38: return m_snap[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge with the given bus write.
    task automatic m_step(input logic we, input logic [7:0] a, input logic [31:0] d);
        bit tk, pre, inc;
        logic [31:0] nlo;
        logic [5:0] hit, clr;
        tk  = (m_pc == 2 * m_div + 1);
        pre = we && (a == 8'h00 || a == 8'h04);
        inc = tk && !pre;
        nlo = 32'(m_cnt + 64'd1);
        for (int n = 0; n < 6; n++) hit[n] = inc && (nlo == m_match[n]);
        m_irq = |(m_stat & m_ie);
        if (hit[5] && m_wde) m_wdog = 1;
        clr = (we && a == 8'h20) ? d[5:0] : 6'd0;
        m_stat = (m_stat & ~clr) | hit;
        m_pc = (we && a == 8'h2C) ? 0 : (tk ? 0 : m_pc + 1);
        if (we && a == 8'h30 && d[0]) m_snap = m_cnt;
        if (we && a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) m_match[(a - 8'h08) >> 2] = d;
        if (we && a == 8'h24) m_ie = d[5:0];
        if (we && a == 8'h28) m_wde = d[0];
        if (we && a == 8'h2C) m_div = longint'(d);
        if (we && a == 8'h00)      m_cnt = {m_cnt[63:32], d};
        else if (we && a == 8'h04) m_cnt = {d, m_cnt[31:0]};
        else if (inc)              m_cnt = m_cnt + 64'd1;
    endtask

    // One bus cycle, entered and left at a falling edge.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
        chk("R8 irq", {63'd0, irq}, {63'd0, m_irq});
        chk("R9 wdog", {63'd0, wdog_rst_req}, {63'd0, m_wdog});
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        chk(tag_of(a), {32'd0, bus_rdata}, {32'd0, m_read(a)});
        @(posedge clk);
        m_step(we, a, d);
        @(negedge clk);
    endtask

    // Idle cycles reading a rotating set of offsets, including an unmapped one.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, (rot == 16) ? 8'h40 : 8'(rot * 4), 32'd0);
            rot = (rot + 1) % 17;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 R10: reset state read across the whole map
        idle(20);
        // R10: writes to unmapped and misaligned offsets change nothing
        cyc(1, 8'h40, 32'hFFFF_FFFF);
        cyc(1, 8'h3C, 32'hFFFF_FFFF);
        cyc(1, 8'h22, 32'hFFFF_FFFF);
        cyc(1, 8'hFC, 32'hFFFF_FFFF);
        cyc(0, 8'hFC, 0);
        cyc(0, 8'h3C, 0);
        idle(17);
        // R1 R2 R5 R8: divider 2, counter near the low-half wrap
        cyc(1, 8'h2C, 32'd2);
        cyc(1, 8'h00, 32'hFFFF_FFF0);
        cyc(1, 8'h04, 32'h0000_0007);
        cyc(1, 8'h08, 32'hFFFF_FFF4);
        cyc(1, 8'h0C, 32'h0000_0001);
        cyc(1, 8'h10, 32'hFFFF_FFF2);
        cyc(1, 8'h1C, 32'hFFFF_FFFA);
        cyc(1, 8'h24, 32'h0000_0003);
        idle(150);
        // R3: latch, ignored latch, latch again
        cyc(1, 8'h30, 32'd1);
        idle(4);
        cyc(1, 8'h30, 32'd0);
        idle(6);
        cyc(1, 8'h30, 32'd3);
        cyc(0, 8'h34, 0);
        cyc(0, 8'h38, 0);
        // R7: clear bit 0 only
        cyc(1, 8'h20, 32'h01);
        cyc(0, 8'h20, 0);
        // R6: clear status 3 while the counter sits on its match value
        cyc(1, 8'h14, 32'h0000_0100);
        cyc(1, 8'h2C, 32'd15);
        cyc(1, 8'h00, 32'h0000_00FF);
        idle(33);
        cyc(1, 8'h20, 32'h08);
        for (int i = 0; i < 20; i++) cyc(0, 8'h20, 0);
        // R8: masking leaves status intact
        cyc(1, 8'h24, 32'h3F);
        idle(4);
        cyc(1, 8'h24, 32'h00);
        idle(4);
        // R9: arm the watchdog on channel 5
        cyc(1, 8'h2C, 32'd0);
        cyc(1, 8'h1C, 32'h0000_0500);
        cyc(1, 8'h28, 32'd1);
        cyc(1, 8'h00, 32'h0000_04FD);
        idle(12);
        // R4: presets back to back at divider 0 collide with ticks
        for (int i = 0; i < 8; i++) begin
            cyc(1, 8'h00, 32'h0000_2000 + 32'(i));
            cyc(0, 8'h00, 0);
        end
        // R7: clears every cycle so one meets the hit on channel 4
        cyc(1, 8'h18, 32'h0000_3000);
        cyc(1, 8'h24, 32'h10);
        cyc(1, 8'h00, 32'h0000_2FFA);
        for (int i = 0; i < 16; i++) cyc(1, 8'h20, 32'h10);
        idle(20);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule